// File: doc/BRIEF.md
# Saturating Phase-Error Up-Down Counter

This block is the counting stage of a digital phase detector inside an all-digital PLL. While a measurement interval is open, the interval controller holds the count enable high. The block then moves a signed two's-complement accumulator by one step per clock, upward or downward according to the direction input. The controller sets the direction from whichever of the two compared edges opened the interval. The accumulator stops at fixed bounds and never wraps, so a long interval still reports the largest error of the correct sign.

When the controller pulses the interval-complete strobe, the block copies the accumulator into an output register. The accumulator then restarts from zero. The output register holds the captured phase error for the loop filter until the next strobe arrives. Only the strobe ends an interval from this block's view. A count enable that falls, for example when the opening signal has a falling edge, only pauses counting and never publishes a result. If it did publish one, the loop could settle half a period out of phase.

There is no state machine. The whole block is an accumulator register and a snapshot register. The next value comes from a one-step adder whose carry out is dropped, together with a pair of bound comparators and a hold multiplexer.

Top module: `phase_err_counter`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator and `phase_err` to zero at the next clock edge.
- R2: With `cnt_en` high and `interval_done` low, the accumulator rises by one per clock when `cnt_up` is 1 and falls by one when `cnt_up` is 0.
- R3: With the default width of 7, the accumulator stays within +63 and -64. A step that would pass a bound leaves the value at that bound.
- R4: With `cnt_en` low, the accumulator keeps its value whatever `cnt_up` shows.
- R5: `phase_err` changes only at a clock edge where `interval_done` or `rst` is high. A falling `cnt_en` alone never alters it.
- R6: At an edge with `interval_done` high, `phase_err` takes the accumulator value including that cycle's step, saturated as in R3.
- R7: After an edge with `interval_done` high, the accumulator is zero, so the next interval starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable, high while the measurement interval is open |
| cnt_up | input | 1 | Direction: 1 counts up, 0 counts down |
| interval_done | input | 1 | Interval-complete strobe that captures and restarts |
| phase_err | output | W (7) | Captured signed phase error |

## Verification
On every cycle the assertions check the following: the one-step moves, holding at either bound, freezing while disabled, clearing after a strobe, including the strobe-cycle step in the capture, and keeping the output still between strobes. The bench sweeps interval lengths in both directions past both bounds. It also runs long streams of mixed enable and direction patterns against an arithmetic saturating model. These scenarios show what the per-cycle checks cannot: that whole intervals sum correctly after pauses, direction reversals, a reset in mid-interval and back-to-back strobes.

// File: rtl/pd_pkg.sv
package pd_pkg;
    localparam int PD_WIDTH_DEFAULT = 7;

    // Direction encoding on cnt_up
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } pd_dir_e;
endpackage

// File: rtl/pd_bound_cmp.sv
module pd_bound_cmp #(
    parameter int W = pd_pkg::PD_WIDTH_DEFAULT
) (
    input  logic [W-1:0] value,
    output logic         at_top,
    output logic         at_bottom
);
    localparam logic [W-1:0] TOP_VAL    = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] BOTTOM_VAL = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        at_top    = (value == TOP_VAL);
        at_bottom = (value == BOTTOM_VAL);
    end
endmodule

// File: rtl/pd_step_adder.sv
module pd_step_adder #(
    parameter int W = pd_pkg::PD_WIDTH_DEFAULT
) (
    input  logic [W-1:0] value,
    input  logic         dir_up,
    output logic [W-1:0] stepped
);
    localparam logic [W-1:0] PLUS_ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MINUS_ONE = {W{1'b1}};

    logic [W-1:0] incr;

    // Down-count adds all-ones; the carry out falls off the W-bit sum.
    always_comb begin
        incr    = dir_up ? PLUS_ONE : MINUS_ONE;
        stepped = value + incr;
    end
endmodule

// File: rtl/phase_err_counter.sv
module phase_err_counter #(
    parameter int W = pd_pkg::PD_WIDTH_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         cnt_up,
    input  logic         interval_done,
    output logic [W-1:0] phase_err
);
    import pd_pkg::*;

    localparam logic [W-1:0] ZERO_VAL   = '0;
    localparam logic [W-1:0] TOP_VAL    = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] BOTTOM_VAL = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE_VAL    = {{(W-1){1'b0}}, 1'b1};

    pd_dir_e      dir;
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_stepped;
    logic [W-1:0] acc_next;
    logic         hit_top;
    logic         hit_bottom;
    logic         blocked;

    assign dir = pd_dir_e'(cnt_up);

    pd_bound_cmp #(.W(W)) u_bounds (
        .value     (acc_q),
        .at_top    (hit_top),
        .at_bottom (hit_bottom)
    );

    pd_step_adder #(.W(W)) u_adder (
        .value   (acc_q),
        .dir_up  (dir == DIR_UP),
        .stepped (acc_stepped)
    );

    // Hold multiplexer: keep the value when disabled or at the bound being pushed.
    always_comb begin
        blocked  = (dir == DIR_UP) ? hit_top : hit_bottom;
        acc_next = (cnt_en && !blocked) ? acc_stepped : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= ZERO_VAL;
            phase_err <= ZERO_VAL;
        end else if (interval_done) begin
            phase_err <= acc_next;
            acc_q     <= ZERO_VAL;
        end else begin
            acc_q     <= acc_next;
        end
    end

    // R2: single steps away from the bounds
    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_up && !interval_done && acc_q != TOP_VAL)
        |=> (acc_q == $past(acc_q) + ONE_VAL));
    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_up && !interval_done && acc_q != BOTTOM_VAL)
        |=> (acc_q == $past(acc_q) - ONE_VAL));

    // R3: bounds hold
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_up && !interval_done && acc_q == TOP_VAL) |=> (acc_q == TOP_VAL));
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        (!cnt_up && !interval_done && acc_q == BOTTOM_VAL) |=> (acc_q == BOTTOM_VAL));

    // R4: frozen when disabled
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !interval_done) |=> $stable(acc_q));

    // R5: output only moves on a strobe
    assert_output_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !interval_done |=> $stable(phase_err));

    // R6: strobe-cycle step included in the capture
    assert_capture_step_R6: assert property (@(posedge clk) disable iff (rst)
        (interval_done && cnt_en && cnt_up && acc_q != TOP_VAL)
        |=> (phase_err == $past(acc_q) + ONE_VAL));
    assert_capture_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (interval_done && !cnt_en) |=> (phase_err == $past(acc_q)));

    // R7: restart from zero
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        interval_done |=> (acc_q == ZERO_VAL));
endmodule

// File: tb/phase_err_counter_tb.sv
module phase_err_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b0;
    logic         cnt_up = 1'b0;
    logic         interval_done = 1'b0;
    logic [W-1:0] phase_err;

    int checks = 0;
    int errors = 0;
    int m_acc = 0;
    int m_out = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_err_counter #(.W(W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .cnt_en        (cnt_en),
        .cnt_up        (cnt_up),
        .interval_done (interval_done),
        .phase_err     (phase_err)
    );

    task automatic check(input string req, input int expv);
        int act;
        act = int'($signed(phase_err));
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s phase_err actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One clock: drive at the falling edge, update the model, compare after the rising edge.
    task automatic cyc(input bit r, input bit en, input bit up, input bit dn, input string req);
        int nxt;
        @(negedge clk);
        rst = r; cnt_en = en; cnt_up = up; interval_done = dn;
        @(posedge clk);
        if (r) begin
            m_acc = 0; m_out = 0;
        end else begin
            nxt = m_acc + (en ? (up ? 1 : -1) : 0);
            if (nxt > 63) nxt = 63;
            if (nxt < -64) nxt = -64;
            if (dn) begin m_out = nxt; m_acc = 0; end
            else m_acc = nxt;
        end
        #1;
        check(req, m_out);
    endtask

    task automatic run(input int n, input bit up, input string req);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, up, 1'b0, req);
    endtask

    task automatic close(input bit en, input bit up, input string req);
        cyc(1'b0, en, up, 1'b1, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        check("R1", 0);
        close(1'b0, 1'b0, "R1");                 // accumulator was zero

        run(10, 1'b1, "R2"); close(1'b0, 1'b0, "R2");    // 10
        run(5, 1'b0, "R2");  close(1'b0, 1'b0, "R2");    // -5

        run(80, 1'b1, "R3"); close(1'b0, 1'b0, "R3");    // 63
        run(80, 1'b0, "R3"); close(1'b0, 1'b0, "R3");    // -64
        run(70, 1'b1, "R3"); run(1, 1'b0, "R3"); close(1'b0, 1'b0, "R3"); // 62
        run(70, 1'b0, "R3"); run(1, 1'b1, "R3"); close(1'b0, 1'b0, "R3"); // -63

        run(3, 1'b1, "R4");
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, i[0], 1'b0, "R4");
        close(1'b0, 1'b1, "R4");                 // 3

        run(4, 1'b1, "R5");
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, "R5"); // falling enable: output held
        close(1'b0, 1'b0, "R5");

        run(2, 1'b1, "R6"); close(1'b1, 1'b1, "R6");     // 3
        run(2, 1'b0, "R6"); close(1'b1, 1'b0, "R6");     // -3
        run(70, 1'b1, "R6"); close(1'b1, 1'b1, "R6");    // 63 at bound

        close(1'b0, 1'b0, "R7");                 // back-to-back: 0
        close(1'b1, 1'b0, "R7");                 // -1

        run(7, 1'b1, "R1");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, "R1");
        close(1'b0, 1'b0, "R1");                 // 0 after mid-interval reset

        for (int len = 0; len <= 130; len++) begin
            run(len, 1'b1, "R3"); close(1'b0, 1'b0, "R3");
            run(len, 1'b0, "R3"); close(1'b0, 1'b0, "R3");
        end

        for (int k = 0; k < 400; k++) begin
            int len;
            len = int'($urandom_range(0, 150));
            for (int i = 0; i < len; i++)
                cyc(1'b0, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), 1'b0, "R6");
            close(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R6");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule